// File: doc/BRIEF.md
# Host Controller Status Register

This block holds the 32-bit status word of a USB 2.0 host controller. It shows whether the controller has halted and whether the periodic and asynchronous schedules are actually running. It also reflects a core flag that marks an empty asynchronous list, and it latches an interrupt that fires after software rings the async-advance doorbell. The block takes the command-side controls as level inputs: Run/Stop, the two schedule enables, and the doorbell pulse. From the controller core it takes three events: stop-complete, schedule-advance and schedule-empty.

Software reads the word at one word-aligned byte address. It clears the interrupt flag by writing 1 to it. A schedule status bit follows its enable only after a fixed, parameterised number of clock edges. The halted bit is tied to Run/Stop through a stop-completion handshake.

Top module: `hc_status_reg`

## Requirements
- R1: After reset the status word reads 0x00001000, so only bit 12 (halted) is set.
- R2: Bit 12 reads 0 in every cycle in which `run_stop_i` is 1, including the cycle in which it first rises.
- R3: Bit 12 becomes 1 at the clock edge that samples `stop_done_i` = 1 while `run_stop_i` = 0. `stop_done_i` has no effect while `run_stop_i` = 1. Bit 12 stays 1 until `run_stop_i` returns to 1.
- R4: Bit 14 follows `per_en_i` and bit 15 follows `async_en_i` at the SCHED_LAG-th clock edge after the enable changed (default 4). Any further change of the enable during that wait restarts the count.
- R5: Bit 13 reads the current value of `async_empty_i`.
- R6: Bit 5 is set at a clock edge that samples `async_adv_i` = 1 after a doorbell pulse was sampled on an earlier edge. An advance event with no pending doorbell leaves bit 5 at 0.
- R7: A write that hits the register with `wr_be_i[0]` = 1 and `wr_data_i[5]` = 1 clears bit 5. A write with data bit 5 = 0, with byte lane 0 disabled, or to another address leaves bit 5 unchanged.
- R8: If a bit-5 set event and a clearing write fall on the same edge, bit 5 is 1 afterwards.
- R9: Writes never change bits 15:12. Bits 31:16, 11:6 and 4:0 always read 0.
- R10: `rd_data_o` carries the status word when `addr_i` bits above bit 1 match BASE_ADDR, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_stop_i | input | 1 | Run/Stop control level |
| per_en_i | input | 1 | Periodic schedule enable level |
| async_en_i | input | 1 | Asynchronous schedule enable level |
| doorbell_i | input | 1 | Async-advance doorbell pulse |
| stop_done_i | input | 1 | Core reports it has finished stopping |
| async_adv_i | input | 1 | Core advanced the asynchronous schedule |
| async_empty_i | input | 1 | Core reports the asynchronous list is empty |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wr_be_i | input | 4 | Byte lane enables of the write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data |

## Verification
Bit 5 can be set by an advance event and cleared by a software write on the same clock edge. The bench provokes this by ringing the doorbell and then, one edge later, presenting an advance pulse together with a write of 1 to bit 5. It judges the outcome by reading bit 5 back as 1 after that edge. A following lone write must then clear the bit, which shows that the collision write was itself valid. A checker property also requires bit 5 to be 1 after every set event, whatever write came with it.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int HALT_BIT  = 12;
  localparam int RECL_BIT  = 13;
  localparam int PER_BIT   = 14;
  localparam int ASY_BIT   = 15;
  localparam int IAA_BIT   = 5;
  localparam logic [31:0] RESET_WORD = 32'h0000_1000;

  // Counter preload so that the copy lands on the lag-th edge after a change.
  function automatic int lag_preload(input int lag);
    return (lag > 1) ? lag - 1 : 0;
  endfunction

  function automatic logic [31:0] pack_status(input logic halted, input logic recl,
                                              input logic per_st, input logic asy_st,
                                              input logic iaa);
    logic [31:0] w;
    w = '0;
    w[HALT_BIT] = halted;
    w[RECL_BIT] = recl;
    w[PER_BIT]  = per_st;
    w[ASY_BIT]  = asy_st;
    w[IAA_BIT]  = iaa;
    return w;
  endfunction
endpackage

// File: rtl/hcs_sched_lag.sv
module hcs_sched_lag #(
  parameter int LAG = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic status_o
);
  localparam int CW = $clog2(LAG + 1);
  localparam logic [CW-1:0] PRE = CW'(hcs_pkg::lag_preload(LAG));

  logic [CW-1:0] cnt_q;
  logic          en_q;
  logic          st_q;
  logic          change_w;

  assign change_w = (en_i != en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      en_q <= en_i;
      if (change_w) begin
        if (LAG <= 1) st_q <= en_i;
        else          cnt_q <= PRE;
      end else if (cnt_q == CW'(1)) begin
        st_q  <= en_i;
        cnt_q <= '0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/hcs_halt_track.sv
module hcs_halt_track (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic stop_done_i,
  output logic halted_o
);
  logic halted_q;
  logic stop_seen_w;

  assign stop_seen_w = ~run_i & stop_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n)           halted_q <= 1'b1;
    else if (run_i)       halted_q <= 1'b0;
    else if (stop_seen_w) halted_q <= 1'b1;
  end

  assign halted_o = halted_q & ~run_i;
endmodule

// File: rtl/hcs_iaa_flag.sv
module hcs_iaa_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic doorbell_i,
  input  logic adv_i,
  input  logic clr_i,
  output logic set_ev_o,
  output logic flag_o
);
  logic armed_q;
  logic flag_q;

  assign set_ev_o = adv_i & armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      armed_q <= doorbell_i | (armed_q & ~adv_i);
      flag_q  <= set_ev_o | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/hc_status_reg.sv
module hc_status_reg #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h24,
  parameter int SCHED_LAG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_stop_i,
  input  logic              per_en_i,
  input  logic              async_en_i,
  input  logic              doorbell_i,
  input  logic              stop_done_i,
  input  logic              async_adv_i,
  input  logic              async_empty_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_be_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o
);
  localparam int N_SCHED = 2;

  logic [N_SCHED-1:0] en_vec;
  logic [N_SCHED-1:0] sched_st;
  logic               halted_w;
  logic               hit_w;
  logic               iaa_clr_w;
  logic               iaa_set_w;
  logic               iaa_w;
  logic [31:0]        status_w;
  logic               unused_bits;

  assign en_vec = {async_en_i, per_en_i};

  for (genvar g = 0; g < N_SCHED; g++) begin : g_sched
    hcs_sched_lag #(.LAG(SCHED_LAG)) u_lag (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_vec[g]),
      .status_o (sched_st[g])
    );
  end

  hcs_halt_track u_halt (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_stop_i),
    .stop_done_i (stop_done_i),
    .halted_o    (halted_w)
  );

  assign hit_w     = (addr_i[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign iaa_clr_w = wr_en_i & hit_w & wr_be_i[0] & wr_data_i[hcs_pkg::IAA_BIT];

  hcs_iaa_flag u_iaa (
    .clk        (clk),
    .rst_n      (rst_n),
    .doorbell_i (doorbell_i),
    .adv_i      (async_adv_i),
    .clr_i      (iaa_clr_w),
    .set_ev_o   (iaa_set_w),
    .flag_o     (iaa_w)
  );

  assign status_w  = hcs_pkg::pack_status(halted_w, async_empty_i, sched_st[0],
                                          sched_st[1], iaa_w);
  assign rd_data_o = hit_w ? status_w : 32'h0;

  assign unused_bits = ^{wr_data_i[31:6], wr_data_i[4:0], wr_be_i[3:1], addr_i[1:0]};
endmodule

// File: rtl/hc_status_chk.sv
module hc_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_stop_i,
  input logic        stop_done_i,
  input logic        async_adv_i,
  input logic        per_en_i,
  input logic        async_en_i,
  input logic [31:0] rd_data_o,
  input logic [31:0] status_w,
  input logic        iaa_set_w,
  input logic        iaa_clr_w
);
  assert_halt_low_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_stop_i |-> !status_w[12]);

  assert_halt_needs_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_w[12]) |-> ($past(stop_done_i) && !$past(run_stop_i)));

  assert_per_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w[14] != $past(status_w[14])) |-> (status_w[14] == $past(per_en_i)));

  assert_asy_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w[15] != $past(status_w[15])) |-> (status_w[15] == $past(async_en_i)));

  assert_iaa_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_w[5]) |-> $past(async_adv_i));

  assert_iaa_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iaa_clr_w && !iaa_set_w) |=> !status_w[5]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iaa_set_w |=> status_w[5]);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[31:16] == 16'h0) && (rd_data_o[11:6] == 6'h0) && (rd_data_o[4:0] == 5'h0));

  assert_read_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o != 32'h0) |-> (rd_data_o == status_w));
endmodule

bind hc_status_reg hc_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_stop_i  (run_stop_i),
  .stop_done_i (stop_done_i),
  .async_adv_i (async_adv_i),
  .per_en_i    (per_en_i),
  .async_en_i  (async_en_i),
  .rd_data_o   (rd_data_o),
  .status_w    (status_w),
  .iaa_set_w   (iaa_set_w),
  .iaa_clr_w   (iaa_clr_w)
);

// File: tb/hc_status_reg_test.sv
module hc_status_reg_test;
  localparam logic [11:0] BASE  = 12'h024;
  localparam logic [11:0] OTHER = 12'h028;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_stop_i, per_en_i, async_en_i, doorbell_i;
  logic        stop_done_i, async_adv_i, async_empty_i;
  logic [11:0] addr_i;
  logic        wr_en_i;
  logic [3:0]  wr_be_i;
  logic [31:0] wr_data_i;
  logic [31:0] rd_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  hc_status_reg #(.ADDR_W(12), .BASE_ADDR(BASE), .SCHED_LAG(4)) uut (
    .clk(clk), .rst_n(rst_n), .run_stop_i(run_stop_i), .per_en_i(per_en_i),
    .async_en_i(async_en_i), .doorbell_i(doorbell_i), .stop_done_i(stop_done_i),
    .async_adv_i(async_adv_i), .async_empty_i(async_empty_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_be_i(wr_be_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o)
  );

  // Row layout: {run, per_en, async_en, stop_done, empty, expected read word}
  localparam logic [36:0] VEC [19] = '{
    {5'b00000, 32'h0000_1000}, {5'b10000, 32'h0000_0000}, {5'b11000, 32'h0000_0000},
    {5'b11000, 32'h0000_0000}, {5'b11000, 32'h0000_0000}, {5'b11000, 32'h0000_4000},
    {5'b11101, 32'h0000_6000}, {5'b11100, 32'h0000_4000}, {5'b11000, 32'h0000_4000},
    {5'b11000, 32'h0000_4000}, {5'b11000, 32'h0000_4000}, {5'b11000, 32'h0000_4000},
    {5'b10010, 32'h0000_4000}, {5'b00000, 32'h0000_4000}, {5'b00000, 32'h0000_4000},
    {5'b00010, 32'h0000_1000}, {5'b00000, 32'h0000_1000}, {5'b10000, 32'h0000_0000},
    {5'b00000, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: read %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic db, input logic adv, input logic sd, input logic wr,
                      input logic [3:0] be, input logic [31:0] data, input logic [11:0] addr);
    @(negedge clk);
    doorbell_i = db; async_adv_i = adv; stop_done_i = sd;
    wr_en_i = wr; wr_be_i = be; wr_data_i = data; addr_i = addr;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_stop_i = 0; per_en_i = 0; async_en_i = 0; doorbell_i = 0;
    stop_done_i = 0; async_adv_i = 0; async_empty_i = 0; addr_i = BASE;
    wr_en_i = 0; wr_be_i = 4'h0; wr_data_i = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset word", rd_data_o, 32'h0000_1000);

    // R2 R3 R4 R5: halt handshake, schedule lag and empty flag, one row per edge
    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      run_stop_i    = VEC[i][36];
      per_en_i      = VEC[i][35];
      async_en_i    = VEC[i][34];
      stop_done_i   = VEC[i][33];
      async_empty_i = VEC[i][32];
      @(posedge clk);
      #1;
      check($sformatf("R2/R3/R4/R5 table row %0d", i), rd_data_o, VEC[i][31:0]);
    end

    // R6: advance with no pending doorbell must not set bit 5
    step(0, 1, 0, 0, 4'h0, 32'h0, BASE);
    check("R6 advance without doorbell", rd_data_o, 32'h0000_0000);
    step(1, 0, 0, 0, 4'h0, 32'h0, BASE);
    check("R6 doorbell alone", rd_data_o, 32'h0000_0000);
    step(0, 1, 0, 0, 4'h0, 32'h0, BASE);
    check("R6 doorbell then advance", rd_data_o, 32'h0000_0020);

    // R7: writes that must not clear
    step(0, 0, 0, 1, 4'h0, 32'h0000_0020, BASE);
    check("R7 lane 0 disabled", rd_data_o, 32'h0000_0020);
    step(0, 0, 0, 1, 4'h1, 32'h0000_0000, BASE);
    check("R7 data zero", rd_data_o, 32'h0000_0020);
    step(0, 0, 0, 1, 4'hF, 32'h0000_0020, OTHER);
    check("R10 other address reads zero", rd_data_o, 32'h0000_0000);
    step(0, 0, 0, 0, 4'h0, 32'h0, BASE);
    check("R7 other address write", rd_data_o, 32'h0000_0020);

    // R3 then R9: halted bit survives an all-ones write, reserved bits stay 0
    step(0, 0, 1, 0, 4'h0, 32'h0, BASE);
    check("R3 stop complete", rd_data_o, 32'h0000_1020);
    step(0, 0, 0, 1, 4'hF, 32'hFFFF_FFFF, BASE);
    check("R9 R7 all-ones write", rd_data_o, 32'h0000_1000);

    // R8: set and clear on the same edge
    step(1, 0, 0, 0, 4'h0, 32'h0, BASE);
    step(0, 1, 0, 1, 4'h1, 32'h0000_0020, BASE);
    check("R8 set beats clear", rd_data_o, 32'h0000_1020);
    step(0, 0, 0, 1, 4'h1, 32'h0000_0020, BASE);
    check("R7 lone clear", rd_data_o, 32'h0000_1000);

    // R1: reset with state present
    step(1, 0, 0, 0, 4'h0, 32'h0, BASE);
    step(0, 1, 0, 0, 4'h0, 32'h0, BASE);
    step(0, 0, 0, 0, 4'h0, 32'h0, BASE);
    check("R6 set before reset", rd_data_o, 32'h0000_1020);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 word after second reset", rd_data_o, 32'h0000_1000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule